// File: doc/BRIEF.md
# Dual-Link Pixel Output Mode Controller

This block is the output stage of one receiver in a pair of receivers that together feed a flat-panel pixel bus. Each receiver is strapped as either the primary or the secondary. The secondary's synchronized sync-detect leaves on `sync_out` and is wired to the primary's `peer_sync`. The primary uses that input to pick its mode. With no peer present, the primary packs two consecutive input pixels onto its even and odd buses, using a half-rate output strobe. With a peer present, the primary passes one pixel per clock onto its even bus and releases the odd bus, so that the secondary can drive odd pixels there.

Every output group has a registered enable that models a tri-state pad. Only the primary ever enables the control outputs and the output clock. The primary changes mode only when a new line starts, so a pixel pair is never split. Data lines are expected to hold an even number of pixels while the two-pixel mode is in use.

Top module: `pixout_ctl`

## Requirements
- R1: `sync_local` passes through two flops; `sync_out` shows a level change after exactly the second rising clock edge that samples it.
- R2: As secondary (`is_master`=0) with synchronized sync-detect low, `even_oe`, `odd_oe` and `clk_en` are 0.
- R3: As secondary with synchronized sync-detect high, the pixel sampled at an edge appears on `even_q` after that edge, with `even_oe`=1, `odd_oe`=0 and `clk_en`=1 on every cycle.
- R4: `ctl_oe` is 0 at every cycle for the secondary. For the primary it is 1 from the first edge after reset is released.
- R5: As primary with `peer_sync` low (two-pixel mode), the first pixel of a line (rising `de_in`) and every second pixel after it go to `even_q`. Each following pixel goes to `odd_q`. Both appear after the edge that samples the second pixel of the pair, with `clk_en`=1 for that one cycle and 0 on the cycle before. `even_oe`=`odd_oe`=1.
- R6: As primary with `peer_sync` high (one-pixel mode), each sampled pixel appears on `even_q` one edge later, with `clk_en`=1 every cycle, `even_oe`=1 and `odd_oe`=0.
- R7: A change of `peer_sync` changes the primary's mode, and `odd_oe`, only at the edge that samples a rising `de_in`. The rest of the current line keeps the old mode.
- R8: `de_q`, `hs_q` and `vs_q` carry the values sampled with the pixel that went to the bus last: delayed one edge in one-pixel mode, and sampled with the second pixel of the pair in two-pixel mode.
- R9: While `rst_n` is low, all enables, `clk_en` and `sync_out` are 0.
- R10: A secondary that loses sync-detect drops `even_oe` and `clk_en` at the third edge after `sync_local` falls, without waiting for a line start. It likewise raises them at the third edge after `sync_local` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | Role strap: 1 primary, 0 secondary |
| sync_local | input | 1 | Local link sync-detect, asynchronous |
| peer_sync | input | 1 | Peer's sync-detect, asynchronous (primary only) |
| pix_in | input | PW | Received pixel |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| sync_out | output | 1 | Synchronized local sync-detect, to the peer |
| even_q | output | PW | Even pixel bus |
| even_oe | output | 1 | Even bus drive enable |
| odd_q | output | PW | Odd pixel bus |
| odd_oe | output | 1 | Odd bus drive enable |
| de_q | output | 1 | Output data enable |
| hs_q | output | 1 | Output horizontal sync |
| vs_q | output | 1 | Output vertical sync |
| ctl_oe | output | 1 | Drive enable for controls and output clock |
| clk_en | output | 1 | Output clock strobe (half rate in two-pixel mode) |

## Verification
Data outputs and enables are due one edge after the input that produced them. In two-pixel mode, a pair is due one edge after its second pixel is sampled. Sync-detect effects take two edges to show on `sync_out` and three to show on the enables. The bench drives each input 2 ns after a rising edge and checks the outputs 2 ns after the next edge. Each expected value is tied to the exact edge count it should appear at, and the cycle before a transition is also checked to show the change is not early.

// File: rtl/pixout_ctl.sv
module pixout_ctl #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          sync_local,
  input  logic          peer_sync,
  input  logic [PW-1:0] pix_in,
  input  logic          de_in,
  input  logic          hs_in,
  input  logic          vs_in,
  output logic          sync_out,
  output logic [PW-1:0] even_q,
  output logic          even_oe,
  output logic [PW-1:0] odd_q,
  output logic          odd_oe,
  output logic          de_q,
  output logic          hs_q,
  output logic          vs_q,
  output logic          ctl_oe,
  output logic          clk_en
);

  typedef enum logic [1:0] {M_OFF, M_TWO, M_ONE, M_SLV} mode_t;

  logic [1:0]    loc_sh, peer_sh;
  logic          de_prev, phase;
  logic [PW-1:0] held;
  mode_t         mode_q, target, mode_nxt;

  wire loc_s  = loc_sh[1];
  wire peer_s = peer_sh[1];
  wire rise   = de_in & ~de_prev;
  wire cur_ph = rise ? 1'b0 : phase;
  wire upd    = rise | (mode_q == M_OFF) | (~is_master & ~loc_s);

  assign sync_out = loc_s;

  always_comb begin
    if (!is_master) target = loc_s ? M_SLV : M_OFF;
    else            target = peer_s ? M_ONE : M_TWO;
    mode_nxt = upd ? target : mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_sh  <= '0;
      peer_sh <= '0;
      de_prev <= 1'b0;
      phase   <= 1'b0;
      mode_q  <= M_OFF;
      held    <= '0;
      even_q  <= '0;
      odd_q   <= '0;
      even_oe <= 1'b0;
      odd_oe  <= 1'b0;
      ctl_oe  <= 1'b0;
      clk_en  <= 1'b0;
      de_q    <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      loc_sh  <= {loc_sh[0], sync_local};
      peer_sh <= {peer_sh[0], peer_sync};
      de_prev <= de_in;
      phase   <= ~cur_ph;
      mode_q  <= mode_nxt;
      even_oe <= (mode_nxt != M_OFF);
      odd_oe  <= (mode_nxt == M_TWO);
      ctl_oe  <= is_master;
      clk_en  <= 1'b0;
      case (mode_nxt)
        M_TWO: begin
          if (!cur_ph) begin
            held <= pix_in;
          end else begin
            even_q <= held;
            odd_q  <= pix_in;
            de_q   <= de_in;
            hs_q   <= hs_in;
            vs_q   <= vs_in;
            clk_en <= 1'b1;
          end
        end
        M_ONE, M_SLV: begin
          even_q <= pix_in;
          de_q   <= de_in;
          hs_q   <= hs_in;
          vs_q   <= vs_in;
          clk_en <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R7: the primary leaves a live mode only on a line start
  a_r7_line_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $past(mode_q) != M_OFF && mode_q != $past(mode_q))
      |-> ($past(de_in) && !$past(de_prev)));

  // R4: the secondary never enables controls or clock
  a_r4_slave_no_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && $stable(is_master)) |=> !ctl_oe);

  // R2: lost sync on the secondary releases the buses at the next edge
  a_r2_slave_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !loc_s) |=> (!even_oe && !odd_oe && !clk_en));

  // R5: in two-pixel mode the strobe never runs two cycles back to back
  a_r5_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TWO && clk_en) |=> (mode_q != M_TWO || !clk_en));

  // R6: the odd bus is only enabled by a primary with the even bus enabled
  a_r6_odd_owner: assert property (@(posedge clk) disable iff (!rst_n)
    odd_oe |-> (even_oe && $past(is_master)));

endmodule

// File: tb/sim_pixout_ctl.sv
`timescale 1ns/1ps
module sim_pixout_ctl;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n, is_master, sync_local, peer_sync, de_in, hs_in, vs_in;
  logic [PW-1:0] pix_in;
  logic          sync_out, even_oe, odd_oe, de_q, hs_q, vs_q, ctl_oe, clk_en;
  logic [PW-1:0] even_q, odd_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pixout_ctl #(.PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .sync_local(sync_local),
    .peer_sync(peer_sync), .pix_in(pix_in), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .sync_out(sync_out), .even_q(even_q), .even_oe(even_oe), .odd_q(odd_q),
    .odd_oe(odd_oe), .de_q(de_q), .hs_q(hs_q), .vs_q(vs_q), .ctl_oe(ctl_oe),
    .clk_en(clk_en));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic de, logic [PW-1:0] p, logic h, logic v);
    de_in = de; pix_in = p; hs_in = h; vs_in = v;
    @(posedge clk); #2;
  endtask

  task automatic blank(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic master);
    is_master = master; rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b0, 1'b0);
      check("R9 even_oe", even_oe, 0);
      check("R9 odd_oe", odd_oe, 0);
      check("R9 ctl_oe", ctl_oe, 0);
      check("R9 clk_en", clk_en, 0);
      check("R9 sync_out", sync_out, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic line_two(int n);
    logic [PW-1:0] first = '0;
    for (int j = 0; j < n; j++) begin
      logic [PW-1:0] p = PW'($urandom);
      logic [1:0]    hv = 2'($urandom);
      step(1'b1, p, hv[0], hv[1]);
      check("R5 odd_oe", odd_oe, 1);
      check("R5 even_oe", even_oe, 1);
      if (j % 2 == 0) begin
        first = p;
        check("R5 idle strobe", clk_en, 0);
      end else begin
        check("R5 strobe", clk_en, 1);
        check("R5 even pixel", even_q, first);
        check("R5 odd pixel", odd_q, p);
        check("R8 de two", de_q, 1);
        check("R8 hs two", hs_q, hv[0]);
        check("R8 vs two", vs_q, hv[1]);
      end
    end
  endtask

  task automatic line_one(int n, logic master);
    for (int j = 0; j < n; j++) begin
      logic [PW-1:0] p = PW'($urandom);
      logic [1:0]    hv = 2'($urandom);
      step(1'b1, p, hv[0], hv[1]);
      check(master ? "R6 even pixel" : "R3 even pixel", even_q, p);
      check(master ? "R6 odd_oe" : "R3 odd_oe", odd_oe, 0);
      check(master ? "R6 even_oe" : "R3 even_oe", even_oe, 1);
      check(master ? "R6 strobe" : "R3 strobe", clk_en, 1);
      check("R4 ctl_oe", ctl_oe, master);
      check("R8 hs one", hs_q, hv[0]);
      check("R8 vs one", vs_q, hv[1]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    sync_local = 1'b0; peer_sync = 1'b0;
    do_reset(1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R4 master ctl_oe first edge", ctl_oe, 1);
    blank(3);
    line_two(8);
    blank(3);
    peer_sync = 1'b1;
    line_two(6);
    blank(3);
    line_one(7, 1'b1);
    peer_sync = 1'b0;
    line_one(5, 1'b1);
    blank(3);
    line_two(4);
    for (int r = 0; r < 12; r++) begin
      logic pk = 1'($urandom);
      int   n  = 2 * $urandom_range(2, 8);
      peer_sync = pk;
      blank(3);
      blank(1);
      if (pk) line_one(n, 1'b1); else line_two(n);
    end

    peer_sync = 1'b0;
    do_reset(1'b0);
    blank(4);
    check("R2 even_oe", even_oe, 0);
    check("R2 clk_en", clk_en, 0);
    check("R4 slave ctl_oe", ctl_oe, 0);
    sync_local = 1'b1;
    step(1'b0, '0, 1'b0, 1'b0);
    check("R1 first edge", sync_out, 0);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R1 second edge", sync_out, 1);
    check("R10 not yet on", even_oe, 0);
    step(1'b0, '0, 1'b0, 1'b0);
    check("R10 on third edge", even_oe, 1);
    check("R10 strobe on", clk_en, 1);
    line_one(9, 1'b0);
    sync_local = 1'b0;
    step(1'b1, PW'($urandom), 1'b0, 1'b0);
    check("R1 fall first edge", sync_out, 1);
    step(1'b1, PW'($urandom), 1'b0, 1'b0);
    check("R1 fall second edge", sync_out, 0);
    check("R10 still on", even_oe, 1);
    step(1'b1, PW'($urandom), 1'b0, 1'b0);
    check("R10 off mid-line", even_oe, 0);
    check("R2 clk_en off", clk_en, 0);
    check("R2 odd_oe off", odd_oe, 0);
    check("R4 slave ctl_oe off", ctl_oe, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule